// File: doc/BRIEF.md
# Password Verify and Version Responder

This block sits above the bit layer of a single-wire slave device and serves two auxiliary commands one byte at a time. Bytes written by the bus master arrive on a one-cycle receive strobe. Bytes the master reads are requested with a one-cycle transmit request, and the block answers on the next clock. A bus reset seen by the bit layer is passed in as a one-cycle pulse. It returns the block to its idle point, where it waits for a command byte.

The verify command (C3h) takes a two-byte target address, low byte first. It forces the three least significant address bits to zero and checks whether the result names one of two stored password slots: one for reading and one for full access. At a slot, the block collects eight password bytes, first byte into bits 7:0. It then waits for the strong-pullup-valid indication. Only when that indication arrives inside a fixed window does it report AAh for a match. In every other case it reports FFh.

The version command (CCh) takes two zero bytes. The block then returns two identical copies of the revision byte, which holds the 3-bit revision in its top bits and zeros below. Any byte read that the current command does not define returns FFh, the value of an idle line.

Top module: `pw_verify_version`

## Requirements
- R1: The verify address is aligned before it is decoded: target address T and T with bits 2:0 cleared select the same password slot (for example 7FC5h selects the slot at 7FC0h).
- R2: When the aligned verify address names no password slot, every later read returns FFh. Later received bytes and pullup indications do not change this.
- R3: After a verify whose eight received bytes equal the selected stored password, and with the pullup indication sampled high within the window, every read returns AAh until the next bus reset.
- R4: When the eight received bytes differ from the selected password in any bit, every read after the pullup indication returns FFh.
- R5: Password bytes are taken least significant first: the first received byte is compared with bits 7:0 of the stored password and the eighth with bits 63:56.
- R6: Aligned address READ_PW_ADDR (default 7FC0h) compares against the read password. Aligned address FULL_PW_ADDR (default 7FC8h) compares against the full-access password.
- R7: If the pullup indication is not sampled high within SPU_WINDOW clocks after the last password byte, reads return FFh even for a matching password.
- R8: After CCh followed by two 00h bytes, the first two reads both return {rev_i, 5'b00000}. Every later read returns FFh.
- R9: If either byte after CCh is not 00h, every later read returns FFh until bus reset.
- R10: A bus reset pulse returns the block to idle from any phase, so a new command is accepted afterwards. Reads in idle return FFh.
- R11: After reset, tx_valid_o is low and stays low while no read is requested.
- R12: Each tx_req_i is answered by tx_valid_o high for exactly the following cycle.
- R13: A command byte other than C3h or CCh makes every later read return FFh until bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_rst_i | input | 1 | One-cycle pulse: bus reset detected by the bit layer |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Master read slot group: request one byte |
| tx_valid_o | output | 1 | Response byte valid, one cycle after tx_req_i |
| tx_data_o | output | 8 | Response byte |
| read_pw_i | input | 64 | Stored read password |
| full_pw_i | input | 64 | Stored full-access password |
| rev_i | input | 3 | Revision code |
| spu_ok_i | input | 1 | Strong pullup valid indication |

## Verification
The hardest situation to reach is the pullup window around a matching password. The status depends on when spu_ok_i arrives after the eighth byte, so a correct password alone does not give AAh. The stimulus table gives each verify vector its own pullup delay: early, late past the window, and absent. Each vector also gives a password choice (read, full-access, or a one-bit corruption), so match and window timing are varied separately. Directed sequences then drive a bus reset in the middle of a password and send bytes after a non-password address.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
    localparam logic [7:0] CMD_VERIFY  = 8'hC3;
    localparam logic [7:0] CMD_VERSION = 8'hCC;
    localparam logic [7:0] STAT_MATCH  = 8'hAA;
    localparam logic [7:0] LINE_IDLE   = 8'hFF;
    localparam int         ADDR_W      = 16;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_TA_LO,
        PH_TA_HI,
        PH_PW,
        PH_SPU,
        PH_STATUS,
        PH_VZERO,
        PH_VOUT,
        PH_ONES
    } phase_e;
endpackage

// File: rtl/pvr_addr_match.sv
module pvr_addr_match
    import pvr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] READ_PW_ADDR = 16'h7FC0,
    parameter logic [ADDR_W-1:0] FULL_PW_ADDR = 16'h7FC8
) (
    input  logic [ADDR_W-1:0] raw_addr_i,
    output logic              hit_o,
    output logic              sel_full_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);

    logic [ADDR_W-1:0] aligned;
    logic              hit_read;
    logic              hit_full;

    always_comb begin
        aligned    = raw_addr_i & ALIGN_MASK;
        hit_read   = (aligned == (READ_PW_ADDR & ALIGN_MASK));
        hit_full   = (aligned == (FULL_PW_ADDR & ALIGN_MASK));
        hit_o      = hit_read | hit_full;
        sel_full_o = hit_full;
    end
endmodule

// File: rtl/pvr_pw_cmp.sv
module pvr_pw_cmp #(
    parameter int PW_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  shift_i,
    input  logic [7:0]            byte_i,
    input  logic                  sel_full_i,
    input  logic [8*PW_BYTES-1:0] read_pw_i,
    input  logic [8*PW_BYTES-1:0] full_pw_i,
    output logic                  match_o
);
    localparam int PW_W = 8 * PW_BYTES;

    logic [PW_W-1:0]     shreg_d, shreg_q;
    logic [PW_W-1:0]     ref_pw;
    logic [PW_BYTES-1:0] byte_eq;

    always_comb begin
        shreg_d = shreg_q;
        if (clr_i) begin
            shreg_d = '0;
        end else if (shift_i) begin
            shreg_d = {byte_i, shreg_q[PW_W-1:8]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg_q <= '0;
        else        shreg_q <= shreg_d;
    end

    assign ref_pw = sel_full_i ? full_pw_i : read_pw_i;

    for (genvar gi = 0; gi < PW_BYTES; gi++) begin : g_byte
        assign byte_eq[gi] = (shreg_q[8*gi +: 8] == ref_pw[8*gi +: 8]);
    end

    assign match_o = &byte_eq;
endmodule

// File: rtl/pvr_spu_window.sv
module pvr_spu_window #(
    parameter int SPU_WINDOW = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic arm_i,
    input  logic spu_ok_i,
    output logic accept_o,
    output logic expire_o
);
    localparam int TW = (SPU_WINDOW > 1) ? $clog2(SPU_WINDOW + 1) : 1;
    localparam logic [TW-1:0] LAST = TW'(SPU_WINDOW - 1);

    typedef struct packed {
        logic          running;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        accept_o = 1'b0;
        expire_o = 1'b0;
        if (t_q.running) begin
            if (spu_ok_i) begin
                accept_o  = 1'b1;
                t_d.running = 1'b0;
            end else if (t_q.cnt == LAST) begin
                expire_o  = 1'b1;
                t_d.running = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt + 1'b1;
            end
        end
        if (arm_i) begin
            t_d.running = 1'b1;
            t_d.cnt     = '0;
        end
        if (abort_i) begin
            t_d.running = 1'b0;
            t_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/pw_verify_version.sv
module pw_verify_version
    import pvr_pkg::*;
#(
    parameter int                PW_BYTES     = 8,
    parameter int                REV_W        = 3,
    parameter int                SPU_WINDOW   = 40,
    parameter logic [ADDR_W-1:0] READ_PW_ADDR = 16'h7FC0,
    parameter logic [ADDR_W-1:0] FULL_PW_ADDR = 16'h7FC8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  line_rst_i,
    input  logic                  rx_valid_i,
    input  logic [7:0]            rx_byte_i,
    input  logic                  tx_req_i,
    output logic                  tx_valid_o,
    output logic [7:0]            tx_data_o,
    input  logic [8*PW_BYTES-1:0] read_pw_i,
    input  logic [8*PW_BYTES-1:0] full_pw_i,
    input  logic [REV_W-1:0]      rev_i,
    input  logic                  spu_ok_i
);
    localparam int CNT_W = (PW_BYTES > 2) ? $clog2(PW_BYTES) : 1;
    localparam logic [CNT_W-1:0] PW_LAST  = CNT_W'(PW_BYTES - 1);
    localparam logic [CNT_W-1:0] PAIR_END = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [7:0]       addr_lo;
        logic [CNT_W-1:0] cnt;
        logic             sel_full;
        logic [7:0]       status;
        logic             tx_valid;
        logic [7:0]       tx_data;
    } st_t;

    st_t s_d, s_q;

    logic              pw_clr, pw_shift, pw_match;
    logic              spu_arm, spu_accept, spu_expire;
    logic              a_hit, a_full;
    logic [7:0]        ver_byte;
    logic [ADDR_W-1:0] raw_addr;

    assign ver_byte = {rev_i, {(8 - REV_W){1'b0}}};
    assign raw_addr = {rx_byte_i, s_q.addr_lo};

    pvr_addr_match #(
        .READ_PW_ADDR (READ_PW_ADDR),
        .FULL_PW_ADDR (FULL_PW_ADDR)
    ) u_addr (
        .raw_addr_i (raw_addr),
        .hit_o      (a_hit),
        .sel_full_o (a_full)
    );

    pvr_pw_cmp #(.PW_BYTES(PW_BYTES)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (pw_clr),
        .shift_i    (pw_shift),
        .byte_i     (rx_byte_i),
        .sel_full_i (s_q.sel_full),
        .read_pw_i  (read_pw_i),
        .full_pw_i  (full_pw_i),
        .match_o    (pw_match)
    );

    pvr_spu_window #(.SPU_WINDOW(SPU_WINDOW)) u_spu (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort_i  (line_rst_i),
        .arm_i    (spu_arm),
        .spu_ok_i (spu_ok_i),
        .accept_o (spu_accept),
        .expire_o (spu_expire)
    );

    always_comb begin
        s_d          = s_q;
        s_d.tx_valid = 1'b0;
        pw_clr       = 1'b0;
        pw_shift     = 1'b0;
        spu_arm      = 1'b0;

        if (tx_req_i) begin
            s_d.tx_valid = 1'b1;
            s_d.tx_data  = LINE_IDLE;
            case (s_q.phase)
                PH_STATUS: s_d.tx_data = s_q.status;
                PH_VOUT: begin
                    s_d.tx_data = ver_byte;
                    s_d.cnt     = s_q.cnt + 1'b1;
                    if (s_q.cnt == PAIR_END) s_d.phase = PH_ONES;
                end
                default: s_d.tx_data = LINE_IDLE;
            endcase
        end

        if (rx_valid_i) begin
            case (s_q.phase)
                PH_IDLE: begin
                    s_d.cnt = '0;
                    if (rx_byte_i == CMD_VERIFY)       s_d.phase = PH_TA_LO;
                    else if (rx_byte_i == CMD_VERSION) s_d.phase = PH_VZERO;
                    else                               s_d.phase = PH_ONES;
                end
                PH_TA_LO: begin
                    s_d.addr_lo = rx_byte_i;
                    s_d.phase   = PH_TA_HI;
                end
                PH_TA_HI: begin
                    if (a_hit) begin
                        s_d.phase    = PH_PW;
                        s_d.sel_full = a_full;
                        s_d.cnt      = '0;
                        pw_clr       = 1'b1;
                    end else begin
                        s_d.phase  = PH_STATUS;
                        s_d.status = LINE_IDLE;
                    end
                end
                PH_PW: begin
                    pw_shift = 1'b1;
                    s_d.cnt  = s_q.cnt + 1'b1;
                    if (s_q.cnt == PW_LAST) begin
                        s_d.phase = PH_SPU;
                        spu_arm   = 1'b1;
                    end
                end
                PH_VZERO: begin
                    if (rx_byte_i != 8'h00) begin
                        s_d.phase = PH_ONES;
                    end else if (s_q.cnt == PAIR_END) begin
                        s_d.phase = PH_VOUT;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (s_q.phase == PH_SPU) begin
            if (spu_accept) begin
                s_d.phase  = PH_STATUS;
                s_d.status = pw_match ? STAT_MATCH : LINE_IDLE;
            end else if (spu_expire) begin
                s_d.phase  = PH_STATUS;
                s_d.status = LINE_IDLE;
            end
        end

        if (line_rst_i) begin
            s_d.phase  = PH_IDLE;
            s_d.cnt    = '0;
            s_d.status = LINE_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.phase    <= PH_IDLE;
            s_q.status   <= LINE_IDLE;
            s_q.tx_data  <= LINE_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = s_q.tx_valid;
    assign tx_data_o  = s_q.tx_data;
endmodule

// File: rtl/pvr_checker.sv
module pvr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       line_rst_i,
    input logic       rx_valid_i,
    input logic       tx_req_i,
    input logic       spu_ok_i,
    input logic       tx_valid_o,
    input logic [7:0] tx_data_o
);
    logic       spu_seen_q;
    logic [3:0] rx_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spu_seen_q <= 1'b0;
            rx_cnt_q   <= '0;
        end else if (line_rst_i) begin
            spu_seen_q <= 1'b0;
            rx_cnt_q   <= '0;
        end else begin
            if (spu_ok_i) spu_seen_q <= 1'b1;
            if (rx_valid_i && rx_cnt_q != 4'hF) rx_cnt_q <= rx_cnt_q + 1'b1;
        end
    end

    AST_TX_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_i |=> tx_valid_o); // R12
    AST_TX_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req_i |=> !tx_valid_o); // R11
    AST_MATCH_NEEDS_SPU: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_data_o == 8'hAA) |-> spu_seen_q); // R7
    AST_VERSION_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_data_o != 8'hFF && tx_data_o != 8'hAA) |-> (tx_data_o[4:0] == 5'd0)); // R8
    AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_data_o != 8'hFF) |-> (rx_cnt_q >= 4'd3)); // R10
endmodule

bind pw_verify_version pvr_checker u_pvr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_rst_i (line_rst_i),
    .rx_valid_i (rx_valid_i),
    .tx_req_i   (tx_req_i),
    .spu_ok_i   (spu_ok_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
);

// File: tb/pw_verify_version_bench.sv
module pw_verify_version_bench;
    localparam int          WIN     = 40;
    localparam logic [63:0] RD_PW   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] FU_PW   = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] BAD_PW  = RD_PW ^ 64'h0000_0001_0000_0000;
    localparam logic [2:0]  REV     = 3'b101;
    localparam logic [7:0]  VER_EXP = 8'hA0;
    localparam logic [7:0]  NO_SPU  = 8'hFF;

    // fields: req[55:48] kind[47:40] (0 verify, 1 version) addr[39:24]
    //         pwsel[23:16] (0 read pw, 1 full pw, 2 corrupted) delay[15:8] exp[7:0]
    localparam int NV = 10;
    localparam logic [55:0] VECS [NV] = '{
        {8'd3, 8'd0, 16'h7FC0, 8'd0, 8'd2,   8'hAA}, // R3 match
        {8'd1, 8'd0, 16'h7FC5, 8'd0, 8'd0,   8'hAA}, // R1 unaligned
        {8'd4, 8'd0, 16'h7FC0, 8'd2, 8'd2,   8'hFF}, // R4 one bit off
        {8'd6, 8'd0, 16'h7FC8, 8'd1, 8'd3,   8'hAA}, // R6 full slot
        {8'd6, 8'd0, 16'h7FC8, 8'd0, 8'd3,   8'hFF}, // R6 wrong slot pw
        {8'd7, 8'd0, 16'h7FC0, 8'd0, NO_SPU, 8'hFF}, // R7 no pullup
        {8'd7, 8'd0, 16'h7FC0, 8'd0, 8'd60,  8'hFF}, // R7 late pullup
        {8'd1, 8'd0, 16'h7FCF, 8'd1, 8'd1,   8'hAA}, // R1 top of block
        {8'd4, 8'd0, 16'h7FC0, 8'd1, 8'd5,   8'hFF}, // R4 other pw
        {8'd8, 8'd1, 16'h0000, 8'd0, 8'd0,   VER_EXP} // R8 version
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_rst = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_req = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        spu_ok = 1'b0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pw_verify_version u_pw_verify_version (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_rst_i (line_rst),
        .rx_valid_i (rx_valid),
        .rx_byte_i  (rx_byte),
        .tx_req_i   (tx_req),
        .tx_valid_o (tx_valid),
        .tx_data_o  (tx_data),
        .read_pw_i  (RD_PW),
        .full_pw_i  (FU_PW),
        .rev_i      (REV),
        .spu_ok_i   (spu_ok)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_pw(input logic [63:0] pw);
        for (int i = 0; i < 8; i++) send(pw[8*i +: 8]);
    endtask

    task automatic bus_reset();
        @(negedge clk);
        line_rst = 1'b1;
        @(negedge clk);
        line_rst = 1'b0;
    endtask

    task automatic read(input int req, output logic [7:0] d);
        @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        check(req, {7'd0, tx_valid}, 8'd1, "valid after request");
        d = tx_data;
    endtask

    task automatic pulse_spu(input int delay);
        for (int i = 0; i < delay; i++) @(negedge clk);
        spu_ok = 1'b1;
        @(negedge clk);
        spu_ok = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL all: watchdog expired, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R11: quiet after reset
        check(11, {7'd0, tx_valid}, 8'd0, "tx_valid in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(11, {7'd0, tx_valid}, 8'd0, "tx_valid idle after reset");

        // R10: idle read returns ones
        read(10, d);
        check(10, d, 8'hFF, "idle read");
        // R12: valid lasts exactly one cycle
        @(negedge clk);
        check(12, {7'd0, tx_valid}, 8'd0, "valid drops after one cycle");

        for (int v = 0; v < NV; v++) begin
            logic [55:0] e;
            logic [63:0] pw;
            int          rq;
            e  = VECS[v];
            rq = int'(e[55:48]);
            bus_reset();
            if (e[47:40] == 8'd0) begin
                send(8'hC3);
                send(e[31:24]);
                send(e[39:32]);
                pw = (e[23:16] == 8'd0) ? RD_PW : (e[23:16] == 8'd1) ? FU_PW : BAD_PW;
                send_pw(pw); // R5: least significant byte first
                if (e[15:8] == NO_SPU) repeat (WIN + 10) @(negedge clk);
                else pulse_spu(int'(e[15:8]));
                if (e[15:8] != NO_SPU && e[15:8] > 8'(WIN)) repeat (4) @(negedge clk);
            end else begin
                send(8'hCC);
                send(8'h00);
                send(8'h00);
            end
            read(rq, d);
            check(rq, d, e[7:0], $sformatf("vector %0d first read", v));
            read(rq, d);
            check(rq, d, e[7:0], $sformatf("vector %0d second read", v));
            read(rq, d);
            check(rq, d, (e[47:40] == 8'd1) ? 8'hFF : e[7:0], $sformatf("vector %0d third read", v));
        end

        // R5: byte order reversed must not match
        bus_reset();
        send(8'hC3); send(8'hC0); send(8'h7F);
        for (int i = 7; i >= 0; i--) send(RD_PW[8*i +: 8]);
        pulse_spu(1);
        read(5, d);
        check(5, d, 8'hFF, "reversed byte order");

        // R2: non-password address ignores later bytes and pullup
        bus_reset();
        send(8'hC3); send(8'h10); send(8'h00);
        read(2, d);
        check(2, d, 8'hFF, "non-password address");
        send_pw(RD_PW);
        pulse_spu(0);
        read(2, d);
        check(2, d, 8'hFF, "bytes after non-password address");

        // R9: nonzero dummy byte after version command
        bus_reset();
        send(8'hCC); send(8'h00); send(8'h05);
        read(9, d);
        check(9, d, 8'hFF, "nonzero second dummy");
        bus_reset();
        send(8'hCC); send(8'h01); send(8'h00);
        read(9, d);
        check(9, d, 8'hFF, "nonzero first dummy");

        // R13: unknown command
        bus_reset();
        send(8'h55); send(8'h00); send(8'h00);
        read(13, d);
        check(13, d, 8'hFF, "unknown command");

        // R10: bus reset in the middle of a password
        bus_reset();
        send(8'hC3); send(8'hC0); send(8'h7F);
        send(RD_PW[7:0]); send(RD_PW[15:8]); send(RD_PW[23:16]);
        bus_reset();
        send(8'hCC); send(8'h00); send(8'h00);
        read(10, d);
        check(10, d, VER_EXP, "version after aborted verify");

        // R3: status persists until bus reset, then idle ones
        bus_reset();
        send(8'hC3); send(8'hC8); send(8'h7F);
        send_pw(FU_PW);
        pulse_spu(WIN - 5);
        for (int i = 0; i < 4; i++) begin
            read(3, d);
            check(3, d, 8'hAA, "repeated status");
        end
        bus_reset();
        read(10, d);
        check(10, d, 8'hFF, "idle after status");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule